// File: doc/BRIEF.md
# Page Write Buffer with Commit

This block sits between the byte-level front-end of a serial memory slave and its storage array. A write command hands it a start address. After that, every received data byte is placed in a page latch at the current in-page offset, and only the low offset bits of the address pointer advance. When the bus stop event arrives, the block checks the write-protect input once. If writing is allowed and at least one byte was loaded, the block commits the loaded bytes to the array and holds a busy flag for a fixed, self-timed write period.

Nothing reaches the array before the stop event. A page that receives more bytes than it holds wraps around, and the later bytes replace the earlier ones. A valid bit for each byte records which offsets were loaded, so offsets that were never loaded keep their old array contents. While busy, the block ignores every command, byte and stop, which matches a device that does not respond during its write cycle. The length of the write period is a parameter given in clock cycles.

Top module: `page_commit_buf`

## Requirements
- R1: After reset, busy is 0, arr_we is 0 and addr_ptr is 0.
- R2: A cmd_start while not busy loads addr_ptr with start_addr and clears all byte valid bits. The value is visible on the next cycle.
- R3: Each byte_stb accepted while a command is open stores byte_data at offset addr_ptr[5:0] and marks that offset valid. It then adds one to addr_ptr[5:0] only, wrapping 63 to 0, and leaves the upper address bits unchanged.
- R4: When more than 64 bytes arrive before stop, each later byte overwrites the earlier byte at the same offset, and only the newest value is committed.
- R5: arr_we is never asserted before the stop event of the command, and is asserted only while busy is 1.
- R6: A stop_evt during an open command, with wp_pin low and at least one valid byte, sets busy on the next cycle and holds it for exactly WRITE_CYCLES cycles. Within that window each valid offset is written once, at address {addr_ptr upper bits, offset}, in ascending offset order.
- R7: Offsets not loaded since the last cmd_start are not written, and those array locations keep their contents.
- R8: A stop_evt during an open command with wp_pin high writes nothing and leaves busy at 0. A cmd_start in the very next cycle is accepted.
- R9: Changes on wp_pin after an accepted stop do not alter the write cycle, its writes or its length.
- R10: While busy, cmd_start, byte_stb and stop_evt have no effect: addr_ptr does not change and the committed data is the data present at stop.
- R11: A stop_evt with no valid bytes, or with no open command, writes nothing and leaves busy at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Opens a new write command (one-cycle pulse) |
| start_addr | input | ADDR_W | Start address of the command |
| byte_stb | input | 1 | One received data byte is valid |
| byte_data | input | DATA_W | Data byte |
| stop_evt | input | 1 | Bus stop event (one-cycle pulse) |
| wp_pin | input | 1 | Write protect, high blocks commit; sampled only at stop |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Self-timed write cycle in progress |
| addr_ptr | output | ADDR_W | Current address pointer |

## Verification
The bench drives page overruns that start near the top of a page. A design that carried into the upper address bits would write into the next page, and a design that kept the first value at an offset would commit stale data. It aborts commands through write protect and then issues one-byte commands. A mask that is not cleared would rewrite the old bytes, and a slow return to idle would miss the back-to-back command. During busy it toggles write protect and sends commands, bytes and stops. A design that resampled protect, accepted these inputs or ended the cycle early would show a changed pointer, corrupted array bytes or a wrong busy length.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  typedef enum logic [1:0] {
    PB_IDLE = 2'd0,
    PB_FILL = 2'd1,
    PB_BURN = 2'd2
  } pb_state_e;
endpackage

// File: rtl/pcb_addr_ptr.sv
module pcb_addr_ptr #(
  parameter int ADDR_W = 15,
  parameter int OFFS_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr
);
  // advance only the in-page offset; page bits stay put
  function automatic logic [ADDR_W-1:0] step_in_page(input logic [ADDR_W-1:0] a);
    logic [OFFS_W-1:0] lo;
    lo = a[OFFS_W-1:0] + {{(OFFS_W-1){1'b0}}, 1'b1};
    return {a[ADDR_W-1:OFFS_W], lo};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_addr;
    else if (step) ptr <= step_in_page(ptr);
  end
endmodule

// File: rtl/pcb_page_latch.sv
module pcb_page_latch #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int OFFS_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_mask,
  input  logic              wr_en,
  input  logic [OFFS_W-1:0] wr_offs,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFFS_W-1:0] rd_offs,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              any_valid
);
  logic [DEPTH-1:0][DATA_W-1:0] lane_bus;
  logic [DEPTH-1:0]             mask_bus;

  for (genvar i = 0; i < DEPTH; i++) begin : g_lane
    logic              hit;
    logic [DATA_W-1:0] q;
    logic              v;
    assign hit = wr_en && (wr_offs == OFFS_W'(i));
    always_ff @(posedge clk) begin
      if (hit) q <= wr_data;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)        v <= 1'b0;
      else if (clr_mask) v <= 1'b0;
      else if (hit)      v <= 1'b1;
    end
    assign lane_bus[i] = q;
    assign mask_bus[i] = v;
  end

  assign rd_data   = lane_bus[rd_offs];
  assign rd_valid  = mask_bus[rd_offs];
  assign any_valid = |mask_bus;
endmodule

// File: rtl/pcb_commit_seq.sv
module pcb_commit_seq
  import pcb_pkg::*;
#(
  parameter int DEPTH        = 64,
  parameter int OFFS_W       = 6,
  parameter int WRITE_CYCLES = 625000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_go,
  input  logic              byte_go,
  input  logic              stop_go,
  input  logic              wp,
  input  logic              any_valid,
  output pb_state_e         state,
  output logic              busy,
  output logic              scan_on,
  output logic [OFFS_W-1:0] scan_offs,
  output logic              acc_cmd,
  output logic              acc_byte,
  output logic              acc_commit,
  output logic              acc_abort
);
  localparam int TMR_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(WRITE_CYCLES - 1);
  localparam logic [OFFS_W-1:0] LAST_OFFS = OFFS_W'(DEPTH - 1);

  logic [TMR_W-1:0] tmr_q;
  logic             stop_in_fill;
  logic             burn_done;

  function automatic logic cycle_over(input logic [TMR_W-1:0] t, input logic s);
    return (t == '0) && !s;
  endfunction

  assign stop_in_fill = stop_go && (state == PB_FILL);
  assign acc_commit   = stop_in_fill && !wp && any_valid;
  assign acc_abort    = stop_in_fill && !acc_commit;
  assign acc_cmd      = cmd_go && !stop_go && (state != PB_BURN);
  assign acc_byte     = byte_go && !cmd_go && !stop_go && (state == PB_FILL);
  assign burn_done    = (state == PB_BURN) && cycle_over(tmr_q, scan_on);
  assign busy         = (state == PB_BURN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PB_IDLE;
    end else begin
      unique case (state)
        PB_IDLE: if (acc_cmd) state <= PB_FILL;
        PB_FILL: begin
          if (acc_commit)     state <= PB_BURN;
          else if (acc_abort) state <= PB_IDLE;
        end
        PB_BURN: if (burn_done) state <= PB_IDLE;
        default: state <= PB_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                               tmr_q <= '0;
    else if (acc_commit)                      tmr_q <= TMR_LOAD;
    else if (state == PB_BURN && tmr_q != '0) tmr_q <= tmr_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_on   <= 1'b0;
      scan_offs <= '0;
    end else if (acc_commit) begin
      scan_on   <= 1'b1;
      scan_offs <= '0;
    end else if (scan_on) begin
      if (scan_offs == LAST_OFFS) scan_on <= 1'b0;
      else                        scan_offs <= scan_offs + 1'b1;
    end
  end
endmodule

// File: rtl/page_commit_buf.sv
module page_commit_buf
  import pcb_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 64,
  parameter int WRITE_CYCLES = 625000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_evt,
  input  logic              wp_pin,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              busy,
  output logic [ADDR_W-1:0] addr_ptr
);
  localparam int OFFS_W = $clog2(PAGE_BYTES);

  pb_state_e         state;
  logic              scan_on;
  logic [OFFS_W-1:0] scan_offs;
  logic              acc_cmd, acc_byte, acc_commit, acc_abort;
  logic              any_valid, rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic              collecting;

  assign collecting = (state == PB_FILL);

  pcb_addr_ptr #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(acc_cmd), .load_addr(start_addr),
    .step(acc_byte), .ptr(addr_ptr)
  );

  pcb_page_latch #(.DATA_W(DATA_W), .DEPTH(PAGE_BYTES), .OFFS_W(OFFS_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .clr_mask(acc_cmd), .wr_en(acc_byte),
    .wr_offs(addr_ptr[OFFS_W-1:0]), .wr_data(byte_data), .rd_offs(scan_offs),
    .rd_data(rd_data), .rd_valid(rd_valid), .any_valid(any_valid)
  );

  pcb_commit_seq #(.DEPTH(PAGE_BYTES), .OFFS_W(OFFS_W), .WRITE_CYCLES(WRITE_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_start), .byte_go(byte_stb),
    .stop_go(stop_evt), .wp(wp_pin), .any_valid(any_valid), .state(state),
    .busy(busy), .scan_on(scan_on), .scan_offs(scan_offs), .acc_cmd(acc_cmd),
    .acc_byte(acc_byte), .acc_commit(acc_commit), .acc_abort(acc_abort)
  );

  assign arr_we    = scan_on && rd_valid;
  assign arr_addr  = {addr_ptr[ADDR_W-1:OFFS_W], scan_offs};
  assign arr_wdata = rd_data;
endmodule

// File: rtl/pcb_chk.sv
module pcb_chk #(
  parameter int ADDR_W       = 15,
  parameter int OFFS_W       = 6,
  parameter int WRITE_CYCLES = 625000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [ADDR_W-1:0] addr_ptr,
  input logic              acc_byte,
  input logic              acc_commit,
  input logic              acc_abort,
  input logic              collecting
);
  logic [31:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  // R5
  we_in_burn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  // R6
  burn_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_commit |=> busy);

  // R6
  burn_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == 32'(WRITE_CYCLES)));

  // R6
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (arr_addr[ADDR_W-1:OFFS_W] == addr_ptr[ADDR_W-1:OFFS_W]));

  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_abort |=> (!busy && !collecting));

  // R3
  offs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_byte |=> ((addr_ptr[ADDR_W-1:OFFS_W] == $past(addr_ptr[ADDR_W-1:OFFS_W])) &&
                  (addr_ptr[OFFS_W-1:0] == $past(addr_ptr[OFFS_W-1:0]) + OFFS_W'(1))));

  // R10
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_ptr));
endmodule

bind page_commit_buf pcb_chk #(
  .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
  .addr_ptr(addr_ptr), .acc_byte(acc_byte), .acc_commit(acc_commit),
  .acc_abort(acc_abort), .collecting(collecting)
);

// File: tb/sim_page_commit_buf.sv
`timescale 1ns/1ps
module sim_page_commit_buf;
  localparam int AW = 10;
  localparam int PB = 64;
  localparam int WC = 200;
  localparam int MSZ = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic byte_stb = 1'b0;
  logic [7:0] byte_data = '0;
  logic stop_evt = 1'b0;
  logic wp_pin = 1'b0;
  logic arr_we;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_wdata;
  logic busy;
  logic [AW-1:0] addr_ptr;

  always #4 clk = ~clk;

  page_commit_buf #(.ADDR_W(AW), .DATA_W(8), .PAGE_BYTES(PB), .WRITE_CYCLES(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .start_addr(start_addr),
    .byte_stb(byte_stb), .byte_data(byte_data), .stop_evt(stop_evt), .wp_pin(wp_pin),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata), .busy(busy),
    .addr_ptr(addr_ptr)
  );

  logic [7:0] mem [MSZ];
  logic [7:0] exp_mem [MSZ];
  int wr_cnt;
  bit have_last, order_err;
  logic [5:0] last_off;
  int compared = 0;
  int mism = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (arr_we) begin
      mem[arr_addr] <= arr_wdata;
      wr_cnt = wr_cnt + 1;
      if (have_last && arr_addr[5:0] <= last_off) order_err = 1;
      last_off = arr_addr[5:0];
      have_last = 1;
    end
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) ^ (a >> 4));
  endfunction

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a);
    return {a[AW-1:6], 6'(a[5:0] + 6'd1)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mism++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    end
  endtask

  task automatic txn(input logic [AW-1:0] start, input int n, input bit wp_stop,
                     input bit disturb, input string req);
    logic [AW-1:0] eptr;
    logic [63:0] emask;
    logic [7:0] epage [PB];
    bit commit;
    int blen, diffs;
    logic [7:0] d;
    eptr = start;
    emask = '0;
    cmd_start = 1'b1; start_addr = start;
    @(negedge clk);
    cmd_start = 1'b0;
    chk(addr_ptr == start, "R2", "pointer load", int'(addr_ptr), int'(start));
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      byte_stb = 1'b1; byte_data = d;
      epage[eptr[5:0]] = d;
      emask[eptr[5:0]] = 1'b1;
      eptr = nxt(eptr);
      @(negedge clk);
    end
    byte_stb = 1'b0;
    chk(addr_ptr == eptr, "R3", "pointer after bytes", int'(addr_ptr), int'(eptr));
    wr_cnt = 0; have_last = 0; order_err = 0;
    wp_pin = wp_stop; stop_evt = 1'b1;
    @(negedge clk);
    stop_evt = 1'b0;
    commit = !wp_stop && (emask != '0);
    chk(busy == commit, wp_stop ? "R8" : (n == 0 ? "R11" : "R6"), "busy after stop",
        int'(busy), int'(commit));
    if (commit)
      for (int o = 0; o < PB; o++)
        if (emask[o]) exp_mem[{start[AW-1:6], 6'(o)}] = epage[o];
    blen = 0;
    while (busy && blen < WC + 20) begin
      blen++;
      if (disturb) begin
        if (blen == 1) begin wp_pin = ~wp_pin; cmd_start = 1'b1; start_addr = ~start; end
        if (blen == 2) begin cmd_start = 1'b0; byte_stb = 1'b1; byte_data = 8'hEE; end
        if (blen == 3) begin byte_stb = 1'b0; stop_evt = 1'b1; wp_pin = 1'b1; end
        if (blen == 4) stop_evt = 1'b0;
      end
      @(negedge clk);
    end
    wp_pin = 1'b0;
    chk(blen == (commit ? WC : 0), disturb ? "R9" : "R6", "busy length", blen, commit ? WC : 0);
    if (disturb)
      chk(addr_ptr == eptr, "R10", "pointer held while busy", int'(addr_ptr), int'(eptr));
    chk(wr_cnt == (commit ? $countones(emask) : 0), "R7", "write count", wr_cnt,
        commit ? $countones(emask) : 0);
    chk(!order_err, "R6", "ascending offsets", int'(order_err), 0);
    diffs = 0;
    for (int a = 0; a < MSZ; a++) if (mem[a] !== exp_mem[a]) diffs++;
    chk(diffs == 0, req, "array contents", diffs, 0);
  endtask

  initial begin
    #(8 * 150000);
    compared++; mism++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int a = 0; a < MSZ; a++) begin mem[a] = pat(a); exp_mem[a] = pat(a); end
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    chk(arr_we == 1'b0, "R1", "arr_we in reset", int'(arr_we), 0);
    chk(addr_ptr == '0, "R1", "pointer in reset", int'(addr_ptr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // stop with no open command: R11
    wr_cnt = 0;
    stop_evt = 1'b1; @(negedge clk); stop_evt = 1'b0;
    chk(busy == 1'b0, "R11", "stop while idle", int'(busy), 0);
    chk(wr_cnt == 0, "R11", "no write while idle", wr_cnt, 0);
    @(negedge clk);
    txn(10'h045, 1, 0, 0, "R3");        // single byte
    txn(10'h080, 64, 0, 0, "R6");       // full page
    txn(10'h13C, 70, 0, 0, "R4");       // overrun wrapping near page top
    txn(10'h1C0, 200, 0, 0, "R4");      // several wraps
    txn(10'h200, 10, 1, 0, "R8");       // protected: aborted
    txn(10'h205, 1, 0, 0, "R2");        // back-to-back after abort, mask cleared
    txn(10'h240, 0, 0, 0, "R11");       // no bytes
    txn(10'h2A3, 5, 0, 1, "R10");       // disturbed while busy
    txn(10'h2FE, 3, 0, 0, "R7");        // sparse, crosses offset 63
    for (int k = 0; k < 12; k++)
      txn(AW'($urandom), int'($urandom_range(0, 80)), ($urandom_range(0, 3) == 0),
          ($urandom_range(0, 2) == 0), "R5");
    summary();
    $finish;
  end
endmodule